// File: doc/BRIEF.md
# Carry-Skip Block Adder

This block adds two unsigned operands of parameterised width plus a one-bit carry-in and returns the full sum and the carry-out. The operand width is cut into equal groups of bits. Inside each group the carry moves bit by bit through full-adder cells. Each group also forms the AND of its bit propagate terms. When that AND is true, the carry entering the group goes straight to the next group and does not travel through the group's internal chain. Because of this bypass, the longest carry path is shorter than a plain ripple chain of the same width, and the extra area is small.

By default the group size is the largest divisor of the width that does not exceed the square root of half the width. For a 32-bit adder this gives groups of 4 bits. If the width is not an exact multiple of the group size, elaboration stops with an error. The adder itself is combinational. Its sum and carry-out are captured in output registers, so a result appears one clock after its operands are applied.

Top module: `csk_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum` and `cout` become all zeros at that edge.
- R2: One clock after operands are applied with `rst` low, `{cout, sum}` equals `a + b + cin`, computed WIDTH+1 bits wide.
- R3: When every bit propagates (`b == ~a`), `cout` equals `cin`, and `sum` is all zeros for `cin` = 1 and all ones for `cin` = 0.
- R4: A carry produced in a lower group and reaching a group whose bits all propagate leaves that group unchanged, so it arrives correctly at the higher bits.
- R5: On the longest path (a generate in bit 0, propagate on every following bit, and a top bit that either kills or generates), the sum and carry-out are exact.
- R6: With both operands zero, `sum` equals `cin` zero-extended and `cout` is 0.
- R7: With both operands all ones, `cout` is 1 and `sum` is all ones with bit 0 equal to `cin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry out of the top bit |

## Verification
Random operand pairs with random carry-in check general agreement with integer addition. Random pairs rarely make a carry cross a bypassed group, so directed patterns are added.

The `b == ~a` pair makes every group take its bypass together. With both carry-in values it shows whether the bypassed carry alone decides every sum bit. Patterns that generate in the lowest group and then propagate through one or more higher groups show whether a carry passes correctly from a rippled group into a skipped one.

The two longest-path cases end in a killing top bit and in a generating top bit. They separate a fault in the final group's rippled carry from a fault in the bypass OR. The all-zero and all-one operand pairs cover the cases where no group can skip.

// File: rtl/csk_pkg.sv
package csk_pkg;

  // Integer square root of w/2, rounded down, never below 1.
  function automatic int unsigned half_root(input int unsigned w);
    int unsigned k;
    k = 1;
    while (((k + 1) * (k + 1)) <= (w / 2)) k = k + 1;
    return k;
  endfunction

  // Largest divisor of w that does not exceed the square root of w/2.
  function automatic int unsigned pick_group(input int unsigned w);
    int unsigned k;
    k = half_root(w);
    while (k > 1 && (w % k) != 0) k = k - 1;
    return k;
  endfunction

endpackage

// File: rtl/csk_fa.sv
module csk_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co,
  output logic p
);
  logic g;

  always_comb begin
    p  = x ^ y;
    g  = x & y;
    co = g | (p & ci);
    s  = p ^ ci;
  end
endmodule

// File: rtl/csk_group.sv
module csk_group #(
  parameter int unsigned BLK = 4
) (
  input  logic [BLK-1:0] x,
  input  logic [BLK-1:0] y,
  input  logic           ci,
  output logic [BLK-1:0] s,
  output logic           co,
  output logic           all_p
);
  logic [BLK:0]   chain;
  logic [BLK-1:0] pv;

  assign chain[0] = ci;

  for (genvar j = 0; j < BLK; j++) begin : g_bit
    csk_fa u_fa (
      .x  (x[j]),
      .y  (y[j]),
      .ci (chain[j]),
      .s  (s[j]),
      .co (chain[j+1]),
      .p  (pv[j])
    );
  end

  // Bypass: with every bit propagating, the incoming carry is forwarded.
  always_comb begin
    all_p = &pv;
    co    = (all_p & ci) | chain[BLK];
  end
endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned BLK   = csk_pkg::pick_group(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int unsigned NGRP = WIDTH / BLK;

  if ((WIDTH % BLK) != 0) begin : g_bad_split
    $error("csk_adder: WIDTH %0d is not a multiple of BLK %0d", WIDTH, BLK);
  end

  logic [NGRP:0]    gcarry;
  logic [NGRP-1:0]  blk_cin;
  logic [NGRP-1:0]  blk_cout;
  logic [NGRP-1:0]  blk_allp;
  logic [WIDTH-1:0] sum_c;

  assign gcarry[0] = cin;

  for (genvar i = 0; i < NGRP; i++) begin : g_grp
    assign blk_cin[i]  = gcarry[i];
    assign gcarry[i+1] = blk_cout[i];
    csk_group #(.BLK(BLK)) u_grp (
      .x     (a[i*BLK +: BLK]),
      .y     (b[i*BLK +: BLK]),
      .ci    (blk_cin[i]),
      .s     (sum_c[i*BLK +: BLK]),
      .co    (blk_cout[i]),
      .all_p (blk_allp[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sum_c;
      cout <= gcarry[NGRP];
    end
  end
endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned BLK   = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [WIDTH-1:0]       a,
  input logic [WIDTH-1:0]       b,
  input logic                   cin,
  input logic [WIDTH-1:0]       sum,
  input logic                   cout,
  input logic [WIDTH/BLK-1:0]   blk_cin,
  input logic [WIDTH/BLK-1:0]   blk_cout,
  input logic [WIDTH/BLK-1:0]   blk_allp
);
  localparam int unsigned NGRP = WIDTH / BLK;

  logic seen_rst = 1'b0;
  always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (sum == '0 && cout == 1'b0));

  // R2
  a_r2_sum_match: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && !$past(rst)) |->
      ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)} + (WIDTH+1)'($past(cin)))));

  // R3
  a_r3_all_prop: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && !$past(rst) && (&($past(a) ^ $past(b)))) |->
      (cout == $past(cin) && sum == {WIDTH{~$past(cin)}}));

  // R4: a fully propagating group forwards its incoming carry
  for (genvar i = 0; i < NGRP; i++) begin : g_skip
    a_r4_group_skip: assert property (@(posedge clk) disable iff (rst)
      blk_allp[i] |-> (blk_cout[i] == blk_cin[i]));
  end

  // R6
  a_r6_zero_ops: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && !$past(rst) && $past(a) == '0 && $past(b) == '0) |->
      (cout == 1'b0 && sum == WIDTH'($past(cin))));
endmodule

bind csk_adder csk_adder_chk #(.WIDTH(WIDTH), .BLK(BLK)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a        (a),
  .b        (b),
  .cin      (cin),
  .sum      (sum),
  .cout     (cout),
  .blk_cin  (blk_cin),
  .blk_cout (blk_cout),
  .blk_allp (blk_allp)
);

// File: tb/sim_csk_adder.sv
module sim_csk_adder;
  localparam int unsigned W = 32;

  typedef struct {
    logic [W:0] exp;
    int         stamp;
    string      req;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  item_t q[$];

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  csk_adder #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(string req, logic [W:0] act, logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: applies one operand set and queues the expected result.
  task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic c, string req);
    item_t it;
    @(negedge clk);
    a = x; b = y; cin = c;
    it.exp   = {1'b0, x} + {1'b0, y} + (W+1)'(c);
    it.stamp = cyc;
    it.req   = req;
    q.push_back(it);
  endtask

  // Monitor: results registered at the edge after stamp are read here.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].stamp < cyc) begin
      item_t it;
      it = q.pop_front();
      check(it.req, {cout, sum}, it.exp);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1", {cout, sum}, '0);
    rst = 1'b0;

    // R3: all-propagate pair, both carry-in values
    drive(32'h1234_5678, ~32'h1234_5678, 1'b1, "R3");
    drive(32'h1234_5678, ~32'h1234_5678, 1'b0, "R3");
    drive(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1, "R3");
    // R4: carry generated in group 0, skipped through higher groups
    drive(32'h0000_00F1, 32'h0000_000F, 1'b0, "R4");
    drive(32'h0000_FFF8, 32'h0000_0008, 1'b0, "R4");
    drive(32'h0F0F_0F0F, 32'h00F0_F0F1, 1'b0, "R4");
    // R5: longest path, top bit kills or generates
    drive(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, "R5");
    drive(32'hFFFF_FFFF, 32'h8000_0001, 1'b0, "R5");
    drive(32'h7FFF_FFFE, 32'h0000_0001, 1'b1, "R5");
    // R6: zero operands
    drive('0, '0, 1'b0, "R6");
    drive('0, '0, 1'b1, "R6");
    // R7: all-ones operands
    drive('1, '1, 1'b0, "R7");
    drive('1, '1, 1'b1, "R7");
    // R2: random operands
    for (int i = 0; i < 300; i++)
      drive($urandom, $urandom, 1'($urandom), "R2");
    @(negedge clk);
    @(negedge clk);

    // R1: reset clears a non-zero result
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", {cout, sum}, '0);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule